// File: doc/BRIEF.md
# 16-bit Output Compare Channel with Buffered Compare Value

This block is a single compare channel belonging to a 16-bit timer. On every timer tick it compares the running count against its active compare value. When the two are equal and nothing suppresses the comparison, it emits a one-cycle match event for downstream waveform logic. It also arms a pending bit that raises a sticky interrupt flag on the next tick.

The processor loads the 16-bit compare value over an 8-bit port. It writes the high byte first, and that byte waits in a temporary latch. The low-byte write then moves both bytes into the target register in one system clock cycle. In PWM operation the target is a shadow buffer, which is committed to the active register only on a tick that marks the top or the bottom of the count, as a mode input selects. In non-PWM operation the active register is written directly. A counter-write indication suppresses the match on the following tick. A force strobe produces a match event without touching the flag.

The counter, the mode decode that produces the top and bottom markers, and the interrupt controller sit outside this block and are driven as inputs. The timer clock is a single-cycle `tick` enable in the system clock domain.

Top module: `ocmp_channel`

## Requirements
- R1: While reset is asserted, the active compare value, the shadow buffer, the temporary byte latch and the flag are all zero, so `active_cmp`, `rd_data` and `cmp_flag` read 0.
- R2: `match_evt` is high in the same cycle as a tick on which `cnt_val` equals `active_cmp`, unless that match is suppressed by R10.
- R3: An unsuppressed match on one tick sets `cmp_flag` on the next tick, not earlier.
- R4: `cmp_flag` is cleared by `irq_ack` or by `flag_w1c`. If a flag set is due in the same cycle as a clear, the set wins.
- R5: With `pwm_mode`=0, a low-byte write loads `active_cmp` with {latched high byte, written low byte} on the next clock edge.
- R6: With `pwm_mode`=1, a low-byte write loads only the shadow buffer. `active_cmp` changes only on a commit tick.
- R7: In PWM operation, a commit copies the buffer into the active register on a tick with `top_hit`=1 when `upd_at_top`=1, or on a tick with `bottom_hit`=1 when `upd_at_top`=0. The other marker is ignored.
- R8: A high-byte write on its own changes neither the active register nor the buffer.
- R9: `rd_data` returns, without going through the latch, the register the processor writes: the buffer when `pwm_mode`=1, the active register otherwise. `rd_hi_sel`=1 selects bits 15:8 and `rd_hi_sel`=0 selects bits 7:0.
- R10: A `cnt_wr` pulse suppresses the match on the first tick after it, even when ticks are paused for many cycles. It does not suppress a tick in the same cycle as the pulse.
- R11: `force_strobe` with `pwm_mode`=0 makes `match_evt` high in that cycle and never sets the flag. With `pwm_mode`=1 the strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable, one cycle wide |
| cnt_val | input | 16 | Current counter value |
| pwm_mode | input | 1 | 1 = buffered (PWM) operation, 0 = direct write |
| upd_at_top | input | 1 | Commit point: 1 = top, 0 = bottom |
| top_hit | input | 1 | Counter is at TOP |
| bottom_hit | input | 1 | Counter is at BOTTOM |
| bus_wr_hi | input | 1 | Processor writes the compare high byte |
| bus_wr_lo | input | 1 | Processor writes the compare low byte |
| bus_wdata | input | 8 | Processor write data |
| rd_hi_sel | input | 1 | Read byte select, 1 = high byte |
| cnt_wr | input | 1 | Processor wrote the counter |
| force_strobe | input | 1 | Forced compare request |
| irq_ack | input | 1 | Interrupt serviced, clears the flag |
| flag_w1c | input | 1 | Software wrote one to the flag bit |
| rd_data | output | 8 | Read data from the processor-visible compare register |
| active_cmp | output | 16 | Active compare value |
| match_evt | output | 1 | Match event for waveform logic |
| cmp_flag | output | 1 | Sticky compare interrupt flag |

## Verification
Several rules are checked by the assertions on every cycle:
- The flag rises one tick after a pending match, and a clear lands only when no set is due.
- A suppressed tick never yields a match, and a strobe in PWM operation produces no event.
- The active value holds still across PWM cycles that do not commit, and across high-byte writes.

Some behaviours need the bench's scenarios to be seen:
- The byte assembly across two writes.
- The selection of the commit marker.
- Suppression that survives a long pause between ticks.
- A counter write that lands on the same cycle as a tick.
- The read mux switching between buffer and active register as the mode changes.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef enum logic {
    COMMIT_AT_BOTTOM = 1'b0,
    COMMIT_AT_TOP    = 1'b1
  } commit_sel_e;

  // Decides whether the shadow buffer moves into the active register this cycle.
  function automatic logic commit_due(input logic pwm, input logic tck,
                                      input commit_sel_e sel,
                                      input logic top, input logic bot);
    logic marker;
    marker = (sel == COMMIT_AT_TOP) ? top : bot;
    return pwm & tck & marker;
  endfunction

  // Selects one byte of a word for the processor read port.
  function automatic logic [7:0] pick_byte(input logic [15:0] word, input logic hi);
    return hi ? word[15:8] : word[7:0];
  endfunction

endpackage

// File: rtl/ocmp_wr_path.sv
module ocmp_wr_path
  import ocmp_pkg::*;
#(
  parameter int CMP_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pwm_mode,
  input  logic              upd_at_top,
  input  logic              top_hit,
  input  logic              bottom_hit,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_hi_sel,
  output logic [CMP_W-1:0]  active_q,
  output logic [BYTE_W-1:0] rd_data,
  output logic              commit_now
);

  logic [BYTE_W-1:0] temp_q;
  logic [CMP_W-1:0]  buf_q;
  logic [CMP_W-1:0]  word_in;
  logic [CMP_W-1:0]  visible;
  commit_sel_e       sel;

  assign sel        = commit_sel_e'(upd_at_top);
  assign commit_now = commit_due(pwm_mode, tick, sel, top_hit, bottom_hit);
  assign word_in    = {temp_q, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
    end else if (wr_hi) begin
      temp_q <= wdata;
    end
  end

  // The buffer takes the word only in PWM operation.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (wr_lo && pwm_mode) begin
      buf_q <= word_in;
    end
  end

  // Commit takes the buffer contents from before any write in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (commit_now) begin
      active_q <= buf_q;
    end else if (wr_lo && !pwm_mode) begin
      active_q <= word_in;
    end
  end

  assign visible = pwm_mode ? buf_q : active_q;
  assign rd_data = pick_byte(visible, rd_hi_sel);

endmodule

// File: rtl/ocmp_match_unit.sv
module ocmp_match_unit #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CMP_W-1:0] cnt_val,
  input  logic [CMP_W-1:0] active,
  input  logic             cnt_wr,
  input  logic             force_strobe,
  input  logic             pwm_mode,
  input  logic             irq_ack,
  input  logic             flag_w1c,
  output logic             match_hit,
  output logic             match_evt,
  output logic             pend_q,
  output logic             blk_q,
  output logic             flag_q
);

  logic forced;
  logic flag_set;
  logic flag_clr;

  assign match_hit = tick && (cnt_val == active) && !blk_q;
  assign forced    = force_strobe && !pwm_mode;
  assign match_evt = match_hit || forced;
  assign flag_set  = tick && pend_q;
  assign flag_clr  = irq_ack || flag_w1c;

  // The suppress window opens on a counter write and closes on the next tick.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
    end else if (cnt_wr) begin
      blk_q <= 1'b1;
    end else if (tick) begin
      blk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (tick) begin
      pend_q <= match_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_set) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int CMP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [CMP_W-1:0]   cnt_val,
  input  logic               pwm_mode,
  input  logic               upd_at_top,
  input  logic               top_hit,
  input  logic               bottom_hit,
  input  logic               bus_wr_hi,
  input  logic               bus_wr_lo,
  input  logic [CMP_W/2-1:0] bus_wdata,
  input  logic               rd_hi_sel,
  input  logic               cnt_wr,
  input  logic               force_strobe,
  input  logic               irq_ack,
  input  logic               flag_w1c,
  output logic [CMP_W/2-1:0] rd_data,
  output logic [CMP_W-1:0]   active_cmp,
  output logic               match_evt,
  output logic               cmp_flag
);

  localparam int BYTE_W = CMP_W / 2;

  logic commit_now;
  logic match_hit;
  logic pend_q;
  logic blk_q;

  ocmp_wr_path #(.CMP_W(CMP_W), .BYTE_W(BYTE_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pwm_mode   (pwm_mode),
    .upd_at_top (upd_at_top),
    .top_hit    (top_hit),
    .bottom_hit (bottom_hit),
    .wr_hi      (bus_wr_hi),
    .wr_lo      (bus_wr_lo),
    .wdata      (bus_wdata),
    .rd_hi_sel  (rd_hi_sel),
    .active_q   (active_cmp),
    .rd_data    (rd_data),
    .commit_now (commit_now)
  );

  ocmp_match_unit #(.CMP_W(CMP_W)) u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .cnt_val      (cnt_val),
    .active       (active_cmp),
    .cnt_wr       (cnt_wr),
    .force_strobe (force_strobe),
    .pwm_mode     (pwm_mode),
    .irq_ack      (irq_ack),
    .flag_w1c     (flag_w1c),
    .match_hit    (match_hit),
    .match_evt    (match_evt),
    .pend_q       (pend_q),
    .blk_q        (blk_q),
    .flag_q       (cmp_flag)
  );

endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk #(
  parameter int CMP_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               pwm_mode,
  input logic               bus_wr_hi,
  input logic               bus_wr_lo,
  input logic [CMP_W/2-1:0] bus_wdata,
  input logic               force_strobe,
  input logic               irq_ack,
  input logic               flag_w1c,
  input logic [CMP_W-1:0]   active_cmp,
  input logic               match_evt,
  input logic               cmp_flag,
  input logic               commit_now,
  input logic               match_hit,
  input logic               pend_q,
  input logic               blk_q
);

  // R2
  hit_drives_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> match_evt);

  // R3
  flag_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tick) |=> cmp_flag);

  // R4
  flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_ack || flag_w1c) && !(pend_q && tick)) |=> !cmp_flag);

  // R5
  direct_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && bus_wr_lo && !commit_now) |=> (active_cmp[CMP_W/2-1:0] == $past(bus_wdata)));

  // R6
  buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !commit_now) |=> $stable(active_cmp));

  // R8
  high_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_hi && !bus_wr_lo && !commit_now) |=> $stable(active_cmp));

  // R10
  blocked_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && tick) |-> !match_hit);

  // R11
  force_pwm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_strobe && pwm_mode && !match_hit) |-> !match_evt);

endmodule

bind ocmp_channel ocmp_channel_chk #(.CMP_W(CMP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .pwm_mode     (pwm_mode),
  .bus_wr_hi    (bus_wr_hi),
  .bus_wr_lo    (bus_wr_lo),
  .bus_wdata    (bus_wdata),
  .force_strobe (force_strobe),
  .irq_ack      (irq_ack),
  .flag_w1c     (flag_w1c),
  .active_cmp   (active_cmp),
  .match_evt    (match_evt),
  .cmp_flag     (cmp_flag),
  .commit_now   (commit_now),
  .match_hit    (match_hit),
  .pend_q       (pend_q),
  .blk_q        (blk_q)
);

// File: tb/ocmp_channel_tb.sv
`timescale 1ns/100ps
module ocmp_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, pwm_mode, upd_at_top, top_hit, bottom_hit;
  logic        bus_wr_hi, bus_wr_lo, rd_hi_sel, cnt_wr, force_strobe, irq_ack, flag_w1c;
  logic [15:0] cnt_val;
  logic [7:0]  bus_wdata;
  logic [7:0]  rd_data;
  logic [15:0] active_cmp;
  logic        match_evt, cmp_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ocmp_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val), .pwm_mode(pwm_mode),
    .upd_at_top(upd_at_top), .top_hit(top_hit), .bottom_hit(bottom_hit),
    .bus_wr_hi(bus_wr_hi), .bus_wr_lo(bus_wr_lo), .bus_wdata(bus_wdata),
    .rd_hi_sel(rd_hi_sel), .cnt_wr(cnt_wr), .force_strobe(force_strobe),
    .irq_ack(irq_ack), .flag_w1c(flag_w1c), .rd_data(rd_data),
    .active_cmp(active_cmp), .match_evt(match_evt), .cmp_flag(cmp_flag)
  );

  // Each entry: pwm, high byte, low byte, expected active value, expected read-back value.
  typedef struct packed {
    logic        pwm;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] exp_act;
    logic [15:0] exp_rd;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 8'h12, 8'h34, 16'h1234, 16'h1234},
    '{1'b1, 8'hAB, 8'hCD, 16'h1234, 16'hABCD},
    '{1'b0, 8'hFF, 8'h00, 16'hFF00, 16'hFF00},
    '{1'b1, 8'h00, 8'h01, 16'hFF00, 16'h0001},
    '{1'b0, 8'h80, 8'h7F, 16'h807F, 16'h807F}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr16(input logic [7:0] hi, input logic [7:0] lo);
    bus_wr_hi = 1'b1; bus_wdata = hi; cyc();
    bus_wr_hi = 1'b0; bus_wr_lo = 1'b1; bus_wdata = lo; cyc();
    bus_wr_lo = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    rd_hi_sel = 1'b1; #0.5; v[15:8] = rd_data;
    rd_hi_sel = 1'b0; #0.5; v[7:0]  = rd_data;
  endtask

  // Drives one tick with the given count and samples match_evt before the edge.
  task automatic do_tick(input logic [15:0] c, output logic m);
    tick = 1'b1; cnt_val = c; #1; m = match_evt; cyc();
    tick = 1'b0;
  endtask

  initial begin
    #200000ns;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    logic        m;
    rst_n = 1'b0; tick = 1'b0; pwm_mode = 1'b0; upd_at_top = 1'b1;
    top_hit = 1'b0; bottom_hit = 1'b0; bus_wr_hi = 1'b0; bus_wr_lo = 1'b0;
    bus_wdata = '0; rd_hi_sel = 1'b0; cnt_wr = 1'b0; force_strobe = 1'b0;
    irq_ack = 1'b0; flag_w1c = 1'b0; cnt_val = 16'h0;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 active", active_cmp, 16'h0);
    chk("R1 flag", {15'd0, cmp_flag}, 16'h0);
    rd16(rv); chk("R1 read", rv, 16'h0);
    rst_n = 1'b1; cyc();

    // R5 R6 R9 table walk
    for (int i = 0; i < 5; i++) begin
      pwm_mode = VECS[i].pwm;
      wr16(VECS[i].hi, VECS[i].lo);
      chk(VECS[i].pwm ? "R6 active held" : "R5 active loaded", active_cmp, VECS[i].exp_act);
      rd16(rv); chk("R9 readback", rv, VECS[i].exp_rd);
    end

    // R8 high byte alone: active 807F, pwm=0
    bus_wr_hi = 1'b1; bus_wdata = 8'h55; cyc(); bus_wr_hi = 1'b0; cyc();
    chk("R8 active", active_cmp, 16'h807F);
    rd16(rv); chk("R8 read", rv, 16'h807F);

    // R7 commit marker selection
    pwm_mode = 1'b1; upd_at_top = 1'b1;
    wr16(8'h01, 8'h00);
    bottom_hit = 1'b1; do_tick(16'h0, m); bottom_hit = 1'b0;
    chk("R7 bottom ignored", active_cmp, 16'h807F);
    top_hit = 1'b1; do_tick(16'h0, m); top_hit = 1'b0;
    chk("R7 top commit", active_cmp, 16'h0100);
    upd_at_top = 1'b0;
    wr16(8'h00, 8'h10);
    top_hit = 1'b1; do_tick(16'h0, m); top_hit = 1'b0;
    chk("R7 top ignored", active_cmp, 16'h0100);
    bottom_hit = 1'b1; do_tick(16'h0, m); bottom_hit = 1'b0;
    chk("R7 bottom commit", active_cmp, 16'h0010);
    pwm_mode = 1'b0;
    rd16(rv); chk("R9 direct view", rv, 16'h0010);

    // R2 R3 match and flag timing, active 0x0010
    do_tick(16'h0010, m);
    chk("R2 match", {15'd0, m}, 16'h1);
    chk("R3 flag not early", {15'd0, cmp_flag}, 16'h0);
    cyc();
    chk("R3 flag waits for tick", {15'd0, cmp_flag}, 16'h0);
    do_tick(16'h0020, m);
    chk("R2 no match", {15'd0, m}, 16'h0);
    chk("R3 flag set", {15'd0, cmp_flag}, 16'h1);

    // R4 software clear and acknowledge clear
    flag_w1c = 1'b1; cyc(); flag_w1c = 1'b0;
    chk("R4 w1c", {15'd0, cmp_flag}, 16'h0);
    do_tick(16'h0010, m); do_tick(16'h0020, m);
    chk("R3 flag set again", {15'd0, cmp_flag}, 16'h1);
    irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
    chk("R4 ack", {15'd0, cmp_flag}, 16'h0);
    do_tick(16'h0010, m);
    irq_ack = 1'b1; do_tick(16'h0020, m); irq_ack = 1'b0;
    chk("R4 set wins", {15'd0, cmp_flag}, 16'h1);
    flag_w1c = 1'b1; cyc(); flag_w1c = 1'b0;

    // R10 counter write blocks the next tick despite a pause
    cnt_wr = 1'b1; cyc(); cnt_wr = 1'b0;
    repeat (6) cyc();
    do_tick(16'h0010, m);
    chk("R10 blocked", {15'd0, m}, 16'h0);
    do_tick(16'h0020, m);
    chk("R10 no flag", {15'd0, cmp_flag}, 16'h0);
    do_tick(16'h0010, m);
    chk("R10 unblocked", {15'd0, m}, 16'h1);
    do_tick(16'h0020, m);
    flag_w1c = 1'b1; cyc(); flag_w1c = 1'b0;
    cnt_wr = 1'b1; do_tick(16'h0010, m); cnt_wr = 1'b0;
    chk("R10 same-cycle tick", {15'd0, m}, 16'h1);
    do_tick(16'h0010, m);
    chk("R10 following tick blocked", {15'd0, m}, 16'h0);
    flag_w1c = 1'b1; cyc(); flag_w1c = 1'b0;

    // R11 force strobe
    cnt_val = 16'h0030;
    force_strobe = 1'b1; #1; m = match_evt; cyc(); force_strobe = 1'b0;
    chk("R11 forced event", {15'd0, m}, 16'h1);
    do_tick(16'h0030, m); do_tick(16'h0030, m);
    chk("R11 no flag", {15'd0, cmp_flag}, 16'h0);
    pwm_mode = 1'b1;
    force_strobe = 1'b1; #1; m = match_evt; cyc(); force_strobe = 1'b0;
    chk("R11 ignored in PWM", {15'd0, m}, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule